// File: doc/BRIEF.md
# Abstract Command Busy Tracker

This block owns the busy bit that a debug module shows in its abstract command control/status register. When the engine accepts a command, the bit is set. It stays set until two things have both happened. First, the selected hart must report that it has finished. Second, the debug transport must have spent a configurable number of clocks in its Run-Test/Idle state since the launch. The delay lets a fast model behave like slow silicon, so a debugger's busy-polling and retry paths get exercised.

Inputs:
- a one-cycle launch request;
- a one-cycle hart-finished strobe;
- a one-cycle pulse for every clock the transport spends in Run-Test/Idle;
- the current command-error status;
- the configured idle-cycle delay.

Outputs:
- the busy bit;
- a one-cycle strobe that the surrounding register logic uses to write a "busy" error code into its command-error field.

Top module: `abcmd_busy_tracker`

## Requirements
- R1: After reset, busy_o and busy_err_o are 0.
- R2: A launch_i pulse is accepted when busy_o is 0 and cmd_err_i is zero. busy_o reads 1 from the following cycle.
- R3: A launch_i pulse while cmd_err_i is nonzero is not performed, and busy_o stays 0.
- R4: A launch_i pulse while busy_o is 1 does not reload the delay or restart the command. One cycle later it produces a single-cycle busy_err_o pulse.
- R5: busy_o falls only after a cycle in which idle_tick_i is 1, the hart has already been recorded as finished, and the remaining-cycle counter is zero. The fall is visible one cycle after that tick.
- R6: The counter is loaded with idle_delay_i at launch, and each idle_tick_i decrements it while it is nonzero. With delay D and the hart finishing after j ticks, busy_o falls after the (max(D,j)+1)-th tick counted from launch.
- R7: With idle_delay_i equal to zero, busy_o falls on the first idle tick after the finish has been recorded.
- R8: A hart_done_i pulse while busy_o is 0 has no effect. busy_o stays 0, and a later command still waits for its own finish.
- R9: A finish strobe and an idle tick in the same cycle do not clear busy. The finish is registered first, and the next idle tick clears busy.
- R10: idle_delay_i is sampled only at launch. Changing it while busy does not change when busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | Command launch request, one cycle |
| hart_done_i | input | 1 | Selected hart reports command finished |
| idle_tick_i | input | 1 | Transport spent this cycle in Run-Test/Idle |
| cmd_err_i | input | ERR_W | Current command-error field, zero = clear |
| idle_delay_i | input | CNT_W | Idle cycles required per command |
| busy_o | output | 1 | Abstract command busy bit |
| busy_err_o | output | 1 | Launch attempted while busy: write busy error code |

## Verification
Every result comes out of a single register stage, so a stimulus driven before a rising edge shows its effect once that edge has passed. The bench applies each stimulus for exactly one clock and samples the outputs shortly after that edge, before the next drive.

The main sweep covers delays 0 to 3 and finish positions 0 to 4 ticks after launch. It predicts the tick on which busy falls as max(D,j)+1 and checks busy after every individual tick. busy_err_o is due on the cycle after the offending launch (registered variant) and is checked there and on the cycle after.

// File: rtl/abcmd_pkg.sv
package abcmd_pkg;
   // one-cycle event strobes seen by the tracker in a cycle
   typedef struct packed {
      logic launch;
      logic done;
      logic tick;
   } abcmd_evt_t;

   function automatic logic err_clear(input logic [7:0] err);
      return err == 8'd0;
   endfunction
endpackage

// File: rtl/abcmd_rti_counter.sv
module abcmd_rti_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   output logic             zero_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (tick_i && cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/abcmd_done_flag.sv
module abcmd_done_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic set_i,
   output logic done_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     done_o <= 1'b0;
      else if (clr_i) done_o <= 1'b0;
      else if (set_i) done_o <= 1'b1;
   end
endmodule

// File: rtl/abcmd_busy_ctrl.sv
module abcmd_busy_ctrl
   import abcmd_pkg::*;
#(
   parameter int ERR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  abcmd_evt_t       evt_i,
   input  logic [ERR_W-1:0] cmd_err_i,
   input  logic             done_i,
   input  logic             cnt_zero_i,
   output logic             accept_o,
   output logic             reject_o,
   output logic             busy_o
);
   logic err_ok;
   logic release_c;

   assign err_ok    = (cmd_err_i == '0);
   assign accept_o  = evt_i.launch && !busy_o && err_ok;
   assign reject_o  = evt_i.launch && busy_o;
   assign release_c = evt_i.tick && busy_o && done_i && cnt_zero_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_o <= 1'b0;
      else if (accept_o)  busy_o <= 1'b1;
      else if (release_c) busy_o <= 1'b0;
   end
endmodule

// File: rtl/abcmd_busy_tracker.sv
module abcmd_busy_tracker
   import abcmd_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int ERR_W   = 3,
   parameter bit ERR_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic             hart_done_i,
   input  logic             idle_tick_i,
   input  logic [ERR_W-1:0] cmd_err_i,
   input  logic [CNT_W-1:0] idle_delay_i,
   output logic             busy_o,
   output logic             busy_err_o
);
   initial begin
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (ERR_W >= 1 && ERR_W <= 8)  else $error("ERR_W out of range");
   end

   abcmd_evt_t evt;
   logic accept, reject, done_q, cnt_zero;

   assign evt.launch = launch_i;
   assign evt.done   = hart_done_i;
   assign evt.tick   = idle_tick_i;

   abcmd_busy_ctrl #(.ERR_W(ERR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .cmd_err_i  (cmd_err_i),
      .done_i     (done_q),
      .cnt_zero_i (cnt_zero),
      .accept_o   (accept),
      .reject_o   (reject),
      .busy_o     (busy_o)
   );

   abcmd_done_flag u_done (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .set_i  (evt.done && busy_o),
      .done_o (done_q)
   );

   abcmd_rti_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (idle_delay_i),
      .tick_i     (evt.tick),
      .zero_o     (cnt_zero)
   );

   generate
      if (ERR_REG) begin : g_err_reg
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= reject;
         end
         assign busy_err_o = err_q;
      end else begin : g_err_comb
         assign busy_err_o = reject;
      end
   endgenerate
endmodule

// File: rtl/abcmd_busy_tracker_chk.sv
module abcmd_busy_tracker_chk #(
   parameter int ERR_W   = 3,
   parameter bit ERR_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             launch_i,
   input logic             hart_done_i,
   input logic             idle_tick_i,
   input logic [ERR_W-1:0] cmd_err_i,
   input logic             busy_o,
   input logic             busy_err_o,
   input logic             done_q,
   input logic             cnt_zero
);
   assert_launch_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_i && !busy_o && cmd_err_i == '0) |=> busy_o);

   assert_rise_needs_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(launch_i && cmd_err_i == '0));

   assert_launch_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_i && busy_o && !idle_tick_i) |=> busy_o);

   assert_fall_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(idle_tick_i && done_q && cnt_zero));

   assert_stray_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hart_done_i && !busy_o && !launch_i) |=> !busy_o);

   assert_same_cycle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_q && hart_done_i) |=> busy_o);

   generate
      if (ERR_REG) begin : g_reg
         assert_err_after_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
            busy_err_o |-> $past(launch_i && busy_o));
      end
   endgenerate
endmodule

bind abcmd_busy_tracker abcmd_busy_tracker_chk #(.ERR_W(ERR_W), .ERR_REG(ERR_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .launch_i    (launch_i),
   .hart_done_i (hart_done_i),
   .idle_tick_i (idle_tick_i),
   .cmd_err_i   (cmd_err_i),
   .busy_o      (busy_o),
   .busy_err_o  (busy_err_o),
   .done_q      (done_q),
   .cnt_zero    (cnt_zero)
);

// File: tb/abcmd_busy_tracker_bench.sv
module abcmd_busy_tracker_bench;
   localparam int CNT_W = 4;
   localparam int ERR_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic launch_i = 1'b0, hart_done_i = 1'b0, idle_tick_i = 1'b0;
   logic [ERR_W-1:0] cmd_err_i = '0;
   logic [CNT_W-1:0] idle_delay_i = '0;
   logic busy_o, busy_err_o;
   int vectors = 0, miscompares = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   abcmd_busy_tracker #(.CNT_W(CNT_W), .ERR_W(ERR_W), .ERR_REG(1'b1)) u_abcmd_busy_tracker (
      .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .hart_done_i(hart_done_i),
      .idle_tick_i(idle_tick_i), .cmd_err_i(cmd_err_i), .idle_delay_i(idle_delay_i),
      .busy_o(busy_o), .busy_err_o(busy_err_o));

   task automatic chk(input logic act, input logic exp, input string req);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // drive one cycle of inputs, then sample after the edge
   task automatic cyc(input logic l, input logic d, input logic t);
      @(negedge clk);
      launch_i = l; hart_done_i = d; idle_tick_i = t;
      @(posedge clk); #1;
      launch_i = 0; hart_done_i = 0; idle_tick_i = 0;
   endtask

   // drain any pending command
   task automatic drain();
      for (int i = 0; i < 40 && busy_o; i++) cyc(0, 1, 1);
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         miscompares++; vectors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy_o, 0, "R1 busy");
      chk(busy_err_o, 0, "R1 err");
      @(negedge clk); rst_n = 1;

      // R6/R7 sweep: delay D, finish after j ticks, fall at tick max(D,j)+1
      for (int d = 0; d < 4; d++) begin
         for (int j = 0; j < 5; j++) begin
            int total;
            total = ((d > j) ? d : j) + 1;
            idle_delay_i = CNT_W'(d);
            cyc(1, 0, 0);
            chk(busy_o, 1, "R2 launch");
            for (int k = 1; k <= 6; k++) begin
               if (k == j + 1) begin
                  cyc(0, 1, 0);           // finish between ticks
                  chk(busy_o, 1, "R5 done alone");
               end
               cyc(0, 0, 1);
               chk(busy_o, (k < total) ? 1'b1 : 1'b0, (d == 0) ? "R7 tick" : "R6 tick");
               if (k >= total) break;
            end
            drain();
         end
      end

      // R3: launch blocked by error
      cmd_err_i = 3'd2;
      cyc(1, 0, 0);
      chk(busy_o, 0, "R3 blocked");
      cmd_err_i = '0;

      // R8: stray finish, then new command waits for its own finish
      idle_delay_i = 0;
      cyc(0, 1, 0);
      chk(busy_o, 0, "R8 stray idle");
      cyc(1, 0, 0);
      cyc(0, 0, 1);
      chk(busy_o, 1, "R8 needs own done");
      cyc(0, 1, 0);
      cyc(0, 0, 1);
      chk(busy_o, 0, "R8 done clears");

      // R9: same-cycle finish and tick
      cyc(1, 0, 0);
      cyc(0, 1, 1);
      chk(busy_o, 1, "R9 same cycle");
      cyc(0, 0, 1);
      chk(busy_o, 0, "R9 next tick");

      // R4: launch while busy, no reload
      idle_delay_i = 2;
      cyc(1, 0, 0);
      cyc(0, 1, 1);                 // cnt 2->1, done
      idle_delay_i = 9;
      cyc(1, 0, 0);                 // rejected
      chk(busy_err_o, 1, "R4 err pulse");
      chk(busy_o, 1, "R4 still busy");
      cyc(0, 0, 0);
      chk(busy_err_o, 0, "R4 err single");
      cyc(0, 0, 1);                 // cnt 1->0
      chk(busy_o, 1, "R4 count");
      cyc(0, 0, 1);                 // clears
      chk(busy_o, 0, "R4 no reload");

      // R10: delay change mid-command
      idle_delay_i = 1;
      cyc(1, 0, 0);
      idle_delay_i = 7;
      cyc(0, 1, 1);
      cyc(0, 0, 1);
      chk(busy_o, 0, "R10 launch value");

      // R1: reset mid-command
      cyc(1, 0, 0);
      @(negedge clk); rst_n = 0;
      #1;
      chk(busy_o, 0, "R1 async reset");
      @(negedge clk); rst_n = 1;

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule